// File: doc/BRIEF.md
# Registered Ready/Valid Relay Stage

This block is one registered stage placed between a producer and a consumer that both use a valid/ready handshake. A word is transferred on a side in any clock cycle where that side's valid and ready are both high. The word is an opaque payload of parameterised width, so it may carry data together with any framing bits. The stage moves one word per clock when neither side stalls, and it adds one cycle of latency.

The ready signal sent upstream comes from a flop. It therefore cannot follow the downstream ready in the same cycle. To cover the one cycle in which upstream has not yet seen backpressure, the stage has a second register. When the consumer refuses a word while the producer is still sending, the newly accepted word is parked in that overflow register. Upstream ready then drops on the following clock. Once the consumer accepts again, the stage delivers the held output word first and then the parked word, and upstream ready comes back.

Four control states govern this: empty (starving), moving (transferring), both registers full in the cycle of capture (overflowed), and both registers full and held (stalled). Words never get reordered, lost or duplicated.

Top module: `bp_relay_stage`

## Requirements
- R1: After synchronous reset, `dn_vld` is 0 and `up_rdy` is 1.
- R2: With `up_vld` and `dn_rdy` held at 1, one word is accepted and one word is delivered every clock. `dn_vld` and `up_rdy` stay at 1, and each word appears on `dn_pay` one clock after it is accepted.
- R3: If a word is accepted in a cycle where `dn_vld` is 1 and `dn_rdy` is 0, that word is kept, and `up_rdy` is 0 from the next clock on.
- R4: While `up_rdy` is 0, upstream words are not taken. When `dn_rdy` returns to 1, the held output word transfers first and the kept word becomes the next `dn_pay`. `up_rdy` is 1 again one clock after that first transfer.
- R5: If the output word is taken and no new word is accepted while `up_rdy` is 1, `dn_vld` is 0 on the next clock.
- R6: While `dn_vld` is 1 and `dn_rdy` is 0, `dn_vld` and `dn_pay` are unchanged on the next clock.
- R7: Under any pattern of `up_vld` and `dn_rdy`, delivered words equal accepted words in the same order, with none lost or repeated.
- R8: `up_rdy` changes only at a rising clock edge, never directly in response to `dn_rdy`. It falls only in the clock after a cycle in which the output word was refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_pay | input | W | Payload offered by the producer |
| up_vld | input | 1 | Producer has a word on `up_pay` |
| up_rdy | output | 1 | Stage will take a word this cycle (registered) |
| dn_pay | output | W | Payload offered to the consumer |
| dn_vld | output | 1 | `dn_pay` holds a word |
| dn_rdy | input | 1 | Consumer takes the word this cycle |

## Verification
The critical coincidence is an upstream acceptance falling in the same cycle as a downstream refusal. The new word must then go to the overflow register, not overwrite the output word. The bench provokes this by dropping `dn_rdy` for exactly one cycle during a continuous stream, and by random `dn_rdy` patterns.

It judges the result cycle by cycle: `up_rdy` must fall on the next clock, the held word must stay on `dn_pay`, and the recovery must deliver the two words in order. The second coincidence is a drain of the overflow word in the same cycle as a new acceptance. This is covered by the random phase, in which a scoreboard queue compares every delivered word with the accepted order.

// File: rtl/bp_relay_pkg.sv
package bp_relay_pkg;

  // Control states of the relay stage
  typedef enum logic [1:0] {
    ST_STARVE = 2'd0,  // output register empty, upstream ready
    ST_FLOW   = 2'd1,  // output register full, overflow empty, upstream ready
    ST_OVER   = 2'd2,  // both full, overflow captured on the last edge
    ST_STALL  = 2'd3   // both full, downstream still refusing
  } relay_state_t;

endpackage

// File: rtl/bp_relay_reg.sv
module bp_relay_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/bp_relay_ctrl.sv
module bp_relay_ctrl
  import bp_relay_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic up_vld,
  input  logic dn_rdy,
  output logic up_rdy,
  output logic dn_vld,
  output logic ld_out_in,
  output logic ld_out_ovf,
  output logic ld_ovf
);

  relay_state_t st_q, st_d;
  logic acc, drn;

  assign acc = up_vld & up_rdy;
  assign drn = dn_vld & dn_rdy;

  always_comb begin
    st_d       = st_q;
    ld_out_in  = 1'b0;
    ld_out_ovf = 1'b0;
    ld_ovf     = 1'b0;
    case (st_q)
      ST_STARVE: begin
        if (acc) begin
          ld_out_in = 1'b1;
          st_d      = ST_FLOW;
        end
      end
      ST_FLOW: begin
        if (acc && drn) begin
          ld_out_in = 1'b1;
        end else if (acc) begin
          ld_ovf = 1'b1;
          st_d   = ST_OVER;
        end else if (drn) begin
          st_d = ST_STARVE;
        end
      end
      ST_OVER, ST_STALL: begin
        if (dn_rdy) begin
          ld_out_ovf = 1'b1;
          st_d       = ST_FLOW;
        end else begin
          st_d = ST_STALL;
        end
      end
      default: st_d = ST_STARVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_STARVE;
      up_rdy <= 1'b1;
      dn_vld <= 1'b0;
    end else begin
      st_q   <= st_d;
      up_rdy <= (st_d == ST_STARVE) || (st_d == ST_FLOW);
      dn_vld <= (st_d != ST_STARVE);
    end
  end

  AST_RDY_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(up_rdy) |-> $past(dn_vld && !dn_rdy)); // R8

  AST_RDY_RETURN: assert property (@(posedge clk) disable iff (rst)
    (!up_rdy && dn_rdy) |=> up_rdy); // R4

  AST_CAPTURE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (up_vld && up_rdy && dn_vld && !dn_rdy) |=> !up_rdy); // R3

endmodule

// File: rtl/bp_relay_stage.sv
module bp_relay_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] up_pay,
  input  logic         up_vld,
  output logic         up_rdy,
  output logic [W-1:0] dn_pay,
  output logic         dn_vld,
  input  logic         dn_rdy
);

  logic         ld_out_in, ld_out_ovf, ld_ovf;
  logic [W-1:0] ovf_q;
  logic [W-1:0] out_d;

  bp_relay_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .up_vld    (up_vld),
    .dn_rdy    (dn_rdy),
    .up_rdy    (up_rdy),
    .dn_vld    (dn_vld),
    .ld_out_in (ld_out_in),
    .ld_out_ovf(ld_out_ovf),
    .ld_ovf    (ld_ovf)
  );

  // output register is fed either by the new word or by the parked one
  assign out_d = ld_out_ovf ? ovf_q : up_pay;

  bp_relay_reg #(.W(W)) u_out_reg (
    .clk(clk),
    .rst(rst),
    .en (ld_out_in | ld_out_ovf),
    .d  (out_d),
    .q  (dn_pay)
  );

  bp_relay_reg #(.W(W)) u_ovf_reg (
    .clk(clk),
    .rst(rst),
    .en (ld_ovf),
    .d  (up_pay),
    .q  (ovf_q)
  );

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (dn_vld && !dn_rdy) |=> (dn_vld && $stable(dn_pay))); // R6

  AST_STREAM_RATE: assert property (@(posedge clk) disable iff (rst)
    (up_vld && up_rdy && dn_vld && dn_rdy) |=> (dn_vld && up_rdy && dn_pay == $past(up_pay))); // R2

  AST_STARVE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (up_rdy && !up_vld && dn_vld && dn_rdy) |=> !dn_vld); // R5

  AST_RECOVER_ORDER: assert property (@(posedge clk) disable iff (rst)
    (!up_rdy && dn_rdy) |=> (dn_vld && dn_pay == $past(ovf_q))); // R4

endmodule

// File: tb/bp_relay_stage_bench.sv
`timescale 1ns/100ps
module bp_relay_stage_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] up_pay = '0;
  logic         up_vld = 1'b0;
  logic         dn_rdy = 1'b0;
  logic         up_rdy, dn_vld;
  logic [W-1:0] dn_pay;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] sb[$];
  bit sb_on = 1'b0;

  always #2.5 clk = ~clk;

  bp_relay_stage #(.W(W)) u_bp_relay_stage (
    .clk(clk), .rst(rst), .up_pay(up_pay), .up_vld(up_vld), .up_rdy(up_rdy),
    .dn_pay(dn_pay), .dn_vld(dn_vld), .dn_rdy(dn_rdy)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard: order, loss and duplication (R7)
  always @(posedge clk) begin
    if (!rst && sb_on) begin
      if (dn_vld && dn_rdy) begin
        if (sb.size() == 0) check("R7 delivery with nothing pending", 1, 0);
        else check("R7 delivered word order", dn_pay, sb.pop_front());
      end
      if (up_vld && up_rdy) sb.push_back(up_pay);
    end
  end

  task automatic do_reset();
    rst = 1'b1; up_vld = 1'b0; dn_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 dn_vld after reset", {15'd0, dn_vld}, 0);
    check("R1 up_rdy after reset", {15'd0, up_rdy}, 1);
  endtask

  task automatic t_stream();
    do_reset();
    dn_rdy = 1'b1; up_vld = 1'b1; up_pay = 16'h1000;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      check("R2 dn_vld in stream", {15'd0, dn_vld}, 1);
      check("R2 up_rdy in stream", {15'd0, up_rdy}, 1);
      check("R2 word one clock later", dn_pay, 16'h1000 + 16'(i - 1));
      up_pay = 16'h1000 + 16'(i);
    end
    up_vld = 1'b0;
    @(negedge clk);
    check("R5 empty after drain", {15'd0, dn_vld}, 0);
  endtask

  task automatic t_stall_recover();
    do_reset();
    dn_rdy = 1'b1; up_vld = 1'b1; up_pay = 16'hA0A0;
    @(negedge clk);
    up_pay = 16'hB0B0; dn_rdy = 1'b0;
    check("R2 first word on output", dn_pay, 16'hA0A0);
    @(negedge clk);
    check("R3 up_rdy low after capture", {15'd0, up_rdy}, 0);
    check("R6 held word", dn_pay, 16'hA0A0);
    up_pay = 16'hC0C0;
    // R8: toggling dn_rdy mid-cycle must not move up_rdy
    dn_rdy = 1'b1; #1;
    check("R8 up_rdy independent of dn_rdy", {15'd0, up_rdy}, 0);
    dn_rdy = 1'b0;
    @(negedge clk);
    check("R6 still held while refused", dn_pay, 16'hA0A0);
    check("R6 valid held", {15'd0, dn_vld}, 1);
    check("R4 C not taken while blocked", {15'd0, up_rdy}, 0);
    dn_rdy = 1'b1;
    @(negedge clk);
    check("R4 parked word next", dn_pay, 16'hB0B0);
    check("R4 up_rdy back", {15'd0, up_rdy}, 1);
    @(negedge clk);
    check("R4 C after parked word", dn_pay, 16'hC0C0);
    up_vld = 1'b0;
    @(negedge clk);
    check("R5 dn_vld cleared", {15'd0, dn_vld}, 0);
  endtask

  task automatic t_random();
    do_reset();
    sb.delete();
    sb_on = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      up_vld = ($urandom % 3) != 0;
      dn_rdy = ($urandom % 2) == 0;
      if (up_vld && up_rdy) up_pay = 16'($urandom);
      @(negedge clk);
      if (!(up_vld && up_rdy)) up_pay = 16'($urandom);
    end
    up_vld = 1'b0; dn_rdy = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 nothing left behind", 16'(sb.size()), 0);
    sb_on = 1'b0;
  endtask

  initial begin
    t_reset();
    t_stream();
    t_stall_recover();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule